// File: doc/BRIEF.md
# Configurable Audio Serial Output Port

This block drives one serial data line with stereo PCM samples, one bit per bit-clock period. The bit clock, the left/right clock and the word clock all come from an external clock master. The block samples them with a fast system clock, passes them through synchronizers and finds their edges in the system-clock domain. The system clock must run at least four times faster than the bit clock.

Three static but asynchronously changeable options shape the output timing:

- Which bit-clock edge launches data.
- Whether a frame begins on a left/right transition or on a rising word-clock edge.
- Whether the first data bit is held back by one bit slot, as I2S framing requires.

A mute input forces the line to zero, which is midscale for two's-complement data.

Sample pairs arrive in parallel with a valid/ready handshake. The block takes a pair at the moment a frame begins. If no pair is waiting, it sends the previous pair again and reports an underrun.

Top module: `audio_serial_tx`

## Requirements
- R1: `rst_n` is an asynchronous active-low reset. While it is low, `sdata_out`, `in_ready` and `underrun_o` are 0, and the held sample pair is cleared to zero. After release, a frame that starts without a valid pair sends only zeros.
- R2: When `cfg_launch_rise` is 0, `sdata_out` changes only after a falling `bclk_in` edge and is stable at the next rising edge, where a receiver captures it. When it is 1, the roles of the two edges swap.
- R3: When `cfg_lr_trigger` is 1, a rising `lrclk_in` edge starts a frame and sends the left sample MSB first while `lrclk_in` is high. A falling edge starts the right half with the right sample of the same pair. Every bit slot after the LSB of a half carries 0.
- R4: When `cfg_lr_trigger` is 0, only a rising `wclk_in` edge starts a frame and `lrclk_in` is ignored. The frame sends the left word followed directly by the right word (2×`SAMPLE_W` bits, MSB first), then zeros until the next start.
- R5: When `cfg_msb_delay` is 1, the first bit slot after any start carries 0 and the MSB follows in the second slot. When it is 0, the MSB occupies the first slot.
- R6: While `mute_in` is high, `sdata_out` is 0 in every slot. Sample pairs are still accepted and latched as usual.
- R7: `in_ready` is high for exactly one system-clock cycle at each frame start (left-half or word-mode start, never at a right-half start). A pair is taken when `in_valid` is high in that cycle.
- R8: If `in_valid` is low at a frame start, the previously held pair is sent again and `underrun_o` pulses high for one cycle, on the cycle after `in_ready`.
- R9: A start indication seen between launch edges is remembered. The half it begins starts at the next launch edge.
- R10: All clock, option and mute inputs are asynchronous. Options changed between frames take effect for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4× the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External bit clock |
| lrclk_in | input | 1 | External left/right clock (high = left) |
| wclk_in | input | 1 | External word clock |
| cfg_launch_rise | input | 1 | 0: launch on falling bit-clock edge; 1: launch on rising |
| cfg_lr_trigger | input | 1 | 1: left/right transitions start halves; 0: word-clock rise starts frame |
| cfg_msb_delay | input | 1 | 1: one empty slot before the MSB |
| mute_in | input | 1 | Forces the serial output to zero |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | Pair is taken in this cycle (frame start) |
| sdata_out | output | 1 | Serial data line |
| underrun_o | output | 1 | One-cycle pulse: frame began with no new pair |

## Verification
The assertions check several properties on every cycle:

- The registered data bit holds still between launch events.
- The delay slot after a start with MSB delay enabled is zero.
- `in_ready` only occurs together with a launch event.
- Each underrun pulse follows a ready cycle in which no valid pair was present.
- A settled mute keeps the line low.

Only the bench's scenarios can show the following:

- The bit order and framing of whole frames under each polarity, trigger source and delay setting.
- That the word-clock mode ignores the left/right clock.
- That an underrun resends the earlier pair.
- That a start arriving between launch edges is deferred to the next one.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  // Kind of bit-slot sequence that a start indication begins.
  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_LEFT  = 2'd1,
    SLOT_RIGHT = 2'd2,
    SLOT_WORD  = 2'd3
  } slot_kind_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/ats_sync.sv
module ats_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ats_edge_unit.sv
module ats_edge_unit
  import audio_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_s,
  input  logic       lr_s,
  input  logic       wclk_s,
  input  logic       launch_rise,
  input  logic       trig_lr,
  output logic       launch_evt,
  output slot_kind_e start_kind
);

  logic       bclk_d, lr_d, wclk_d;
  logic       bclk_rise, bclk_fall, lr_rise, lr_fall, wclk_rise;
  slot_kind_e new_kind;
  slot_kind_e pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b0;
      lr_d   <= 1'b0;
      wclk_d <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      lr_d   <= lr_s;
      wclk_d <= wclk_s;
    end
  end

  assign bclk_rise = bclk_s & ~bclk_d;
  assign bclk_fall = ~bclk_s & bclk_d;
  assign lr_rise   = lr_s & ~lr_d;
  assign lr_fall   = ~lr_s & lr_d;
  assign wclk_rise = wclk_s & ~wclk_d;

  assign launch_evt = launch_rise ? bclk_rise : bclk_fall;

  always_comb begin
    new_kind = SLOT_NONE;
    if (trig_lr) begin
      if (lr_rise)      new_kind = SLOT_LEFT;
      else if (lr_fall) new_kind = SLOT_RIGHT;
    end else if (wclk_rise) begin
      new_kind = SLOT_WORD;
    end
  end

  // A start seen off a launch edge waits for the next launch edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend_q <= SLOT_NONE;
    else if (launch_evt)           pend_q <= SLOT_NONE;
    else if (new_kind != SLOT_NONE) pend_q <= new_kind;
  end

  always_comb begin
    if (!launch_evt)               start_kind = SLOT_NONE;
    else if (new_kind != SLOT_NONE) start_kind = new_kind;
    else                           start_kind = pend_q;
  end

endmodule

// File: rtl/ats_shifter.sv
module ats_shifter
  import audio_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch_evt,
  input  slot_kind_e          start_kind,
  input  logic                msb_dly,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                in_valid,
  output logic                in_ready,
  output logic                sdata_q,
  output logic                underrun_o
);

  localparam int unsigned SHIFT_W = 2 * SAMPLE_W;

  // Bit image loaded at a start: words MSB-aligned, zeros fill the rest.
  function automatic logic [SHIFT_W-1:0] slot_image(
    input slot_kind_e          kind,
    input logic [SAMPLE_W-1:0] l,
    input logic [SAMPLE_W-1:0] r
  );
    case (kind)
      SLOT_WORD:  return {l, r};
      SLOT_LEFT:  return {l, {SAMPLE_W{1'b0}}};
      SLOT_RIGHT: return {r, {SAMPLE_W{1'b0}}};
      default:    return '0;
    endcase
  endfunction

  function automatic logic first_bit(input logic [SHIFT_W-1:0] img, input logic dly);
    return dly ? 1'b0 : img[SHIFT_W-1];
  endfunction

  function automatic logic [SHIFT_W-1:0] after_first(input logic [SHIFT_W-1:0] img,
                                                     input logic dly);
    return dly ? img : {img[SHIFT_W-2:0], 1'b0};
  endfunction

  logic [SAMPLE_W-1:0] hold_l, hold_r, cur_l, cur_r;
  logic [SHIFT_W-1:0]  shreg, img;
  logic                frame_evt, load_evt, take;

  assign frame_evt = launch_evt && (start_kind == SLOT_LEFT || start_kind == SLOT_WORD);
  assign load_evt  = launch_evt && (start_kind != SLOT_NONE);
  assign in_ready  = frame_evt;
  assign take      = frame_evt && in_valid;
  assign cur_l     = take ? in_left  : hold_l;
  assign cur_r     = take ? in_right : hold_r;
  assign img       = slot_image(start_kind, cur_l, cur_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l     <= '0;
      hold_r     <= '0;
      shreg      <= '0;
      sdata_q    <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      underrun_o <= frame_evt && !in_valid;
      if (take) begin
        hold_l <= in_left;
        hold_r <= in_right;
      end
      if (load_evt) begin
        sdata_q <= first_bit(img, msb_dly);
        shreg   <= after_first(img, msb_dly);
      end else if (launch_evt) begin
        sdata_q <= shreg[SHIFT_W-1];
        shreg   <= {shreg[SHIFT_W-2:0], 1'b0};
      end
    end
  end

  AST_HOLD_BETWEEN_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_evt |=> $stable(sdata_q)); // R2

  AST_DELAY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && msb_dly) |=> (sdata_q == 1'b0)); // R5

  AST_READY_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> launch_evt); // R7

  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> ($past(in_ready) && !$past(in_valid))); // R8

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 16,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  input  logic                wclk_in,
  input  logic                cfg_launch_rise,
  input  logic                cfg_lr_trigger,
  input  logic                cfg_msb_delay,
  input  logic                mute_in,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                in_valid,
  output logic                in_ready,
  output logic                sdata_out,
  output logic                underrun_o
);

  localparam int unsigned N_ASYNC = 7;

  logic [N_ASYNC-1:0] async_vec, sync_vec;
  logic               bclk_s, lr_s, wclk_s, launch_rise_s, trig_lr_s, msb_dly_s, mute_s;
  logic               launch_evt, sdata_q;
  slot_kind_e         start_kind;

  assign async_vec = {mute_in, cfg_msb_delay, cfg_lr_trigger, cfg_launch_rise,
                      wclk_in, lrclk_in, bclk_in};
  assign {mute_s, msb_dly_s, trig_lr_s, launch_rise_s, wclk_s, lr_s, bclk_s} = sync_vec;

  ats_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (async_vec),
    .sync_o  (sync_vec)
  );

  ats_edge_unit edge_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_s      (bclk_s),
    .lr_s        (lr_s),
    .wclk_s      (wclk_s),
    .launch_rise (launch_rise_s),
    .trig_lr     (trig_lr_s),
    .launch_evt  (launch_evt),
    .start_kind  (start_kind)
  );

  ats_shifter #(.SAMPLE_W(SAMPLE_W)) shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_evt (launch_evt),
    .start_kind (start_kind),
    .msb_dly    (msb_dly_s),
    .in_left    (in_left),
    .in_right   (in_right),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .sdata_q    (sdata_q),
    .underrun_o (underrun_o)
  );

  // Mute overrides the line to midscale; latching is unaffected.
  assign sdata_out = sdata_q & ~mute_s;

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) && $past(mute_in, 2))
      |-> (sdata_out == 1'b0)); // R6

endmodule

// File: tb/audio_serial_tx_tb_top.sv
`timescale 1ns/1ps
module audio_serial_tx_tb_top;

  localparam int W = 16;
  localparam int FRAME_SLOTS = 40;
  localparam int HALF_SLOTS = 20;
  localparam int NVEC = 9;

  // {left, right, valid, launch_rise, lr_trigger, msb_delay, mute}
  localparam logic [36:0] VEC [NVEC] = '{
    {16'hA5C3, 16'h3C5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h8001, 16'h7FFE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'h1234, 16'hFEDC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h0F0F, 16'hF0F0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'hDEAD, 16'hBEEF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'hCAFE, 16'hBEEF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h1357, 16'h2468, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'h5555, 16'hAAAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_in = 1'b1, lrclk_in = 1'b0, wclk_in = 1'b0;
  logic cfg_launch_rise = 1'b0, cfg_lr_trigger = 1'b1, cfg_msb_delay = 1'b0, mute_in = 1'b0;
  logic [W-1:0] in_left = '0, in_right = '0;
  logic in_valid = 1'b0;
  logic in_ready, sdata_out, underrun_o;

  int checks = 0, failures = 0;
  int un_cnt = 0, acc_cnt = 0;
  logic cur_pol = 1'b0;
  logic [W-1:0] prev_l = '0, prev_r = '0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_serial_tx #(.SAMPLE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in), .wclk_in(wclk_in),
    .cfg_launch_rise(cfg_launch_rise), .cfg_lr_trigger(cfg_lr_trigger),
    .cfg_msb_delay(cfg_msb_delay), .mute_in(mute_in), .in_left(in_left),
    .in_right(in_right), .in_valid(in_valid), .in_ready(in_ready),
    .sdata_out(sdata_out), .underrun_o(underrun_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (underrun_o) un_cnt++;
      if (in_ready && in_valid) acc_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Receiver view: bit expected in slot k of a frame.
  function automatic logic exp_bit(int k, logic [W-1:0] l, logic [W-1:0] r,
                                   logic trig, logic dly, logic mute);
    int m;
    logic [W-1:0] wd;
    if (mute) return 1'b0;
    if (trig) begin
      m  = (k % HALF_SLOTS) - int'(dly);
      wd = (k < HALF_SLOTS) ? l : r;
      if (m < 0 || m >= W) return 1'b0;
      return wd[W-1-m];
    end
    m = k - int'(dly);
    if (m < 0) return 1'b0;
    if (m < W) return l[W-1-m];
    if (m < 2*W) return r[2*W-1-m];
    return 1'b0;
  endfunction

  // One bit slot: launch edge, then capture edge where the line is read.
  task automatic do_slot(input logic lr_l, input logic set_l, input logic wc,
                         input logic lr_c, input logic set_c, output logic b);
    @(negedge clk);
    bclk_in = cur_pol;
    if (set_l) lrclk_in = lr_l;
    wclk_in = wc;
    repeat (4) @(negedge clk);
    b = sdata_out;
    bclk_in = ~cur_pol;
    if (set_c) lrclk_in = lr_c;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input logic pol, input logic trig, input logic dly, input logic mute,
                           input logic [W-1:0] l, input logic [W-1:0] r, input logic valid,
                           input logic early, output logic [FRAME_SLOTS-1:0] got,
                           output int nun, output int nacc);
    int u0, a0;
    logic dummy;
    @(negedge clk);
    cfg_launch_rise = pol; cfg_lr_trigger = trig; cfg_msb_delay = dly; mute_in = mute;
    in_left = l; in_right = r; in_valid = valid;
    cur_pol = pol;
    repeat (4) @(negedge clk);
    bclk_in = ~pol;
    repeat (6) @(negedge clk);
    u0 = un_cnt; a0 = acc_cnt;
    if (early) do_slot(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, dummy);
    for (int k = 0; k < FRAME_SLOTS; k++) begin
      do_slot(k < HALF_SLOTS, !early, k == 0, (k + 1) < HALF_SLOTS, early, got[k]);
    end
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    nun = un_cnt - u0;
    nacc = acc_cnt - a0;
  endtask

  task automatic frame_check(input logic pol, input logic trig, input logic dly, input logic mute,
                             input logic [W-1:0] l, input logic [W-1:0] r, input logic valid,
                             input logic early, input string tag);
    logic [FRAME_SLOTS-1:0] got, exp;
    logic [W-1:0] el, er;
    int nun, nacc;
    el = valid ? l : prev_l;
    er = valid ? r : prev_r;
    run_frame(pol, trig, dly, mute, l, r, valid, early, got, nun, nacc);
    for (int k = 0; k < FRAME_SLOTS; k++) exp[k] = exp_bit(k, el, er, trig, dly, mute);
    chk(got == exp, tag, 64'(got), 64'(exp));
    chk(nun == (valid ? 0 : 1), "R8 underrun pulse count", 64'(nun), 64'(valid ? 0 : 1));
    chk(nacc == (valid ? 1 : 0), "R7 pair accept count", 64'(nacc), 64'(valid ? 1 : 0));
    prev_l = el;
    prev_r = er;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [36:0] v;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(sdata_out == 1'b0, "R1 reset sdata_out", 64'(sdata_out), 64'h0);
    chk(in_ready == 1'b0, "R1 reset in_ready", 64'(in_ready), 64'h0);
    chk(underrun_o == 1'b0, "R1 reset underrun_o", 64'(underrun_o), 64'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      if (v[0])       tag = "R6 muted frame";
      else if (!v[2]) tag = "R4 word-clock frame";
      else if (v[1])  tag = "R5 delayed-MSB frame";
      else if (v[3])  tag = "R2 rising-launch frame";
      else            tag = "R3 lr-triggered frame";
      frame_check(v[3], v[2], v[1], v[0], v[36:21], v[20:5], v[4], 1'b0,
                  {tag, (i > 0) ? " R10" : ""});
    end

    // R9: left/right transitions seen at capture edges start at the next launch
    frame_check(1'b0, 1'b1, 1'b0, 1'b0, 16'h6B2D, 16'h93E1, 1'b1, 1'b1, "R9 deferred start");
    frame_check(1'b1, 1'b1, 1'b1, 1'b0, 16'h7001, 16'h800E, 1'b1, 1'b1, "R9 deferred start delayed");

    // R1: reset mid-run clears held pair
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdata_out == 1'b0, "R1 reset sdata_out again", 64'(sdata_out), 64'h0);
    chk(underrun_o == 1'b0, "R1 reset underrun_o again", 64'(underrun_o), 64'h0);
    rst_n = 1'b1;
    prev_l = '0;
    prev_r = '0;
    repeat (4) @(negedge clk);
    frame_check(1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R1 cleared pair after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule